// File: doc/BRIEF.md
# Key Matrix Scanner

This block reads a grid of momentary switches arranged as ROWS drive lines by COLS sense lines. With the defaults that is five rows by six columns, or thirty keys. A host command interface starts a scan with a one-cycle request pulse. The scanner then raises each drive line in turn, from row 0 to the last row, for a fixed dwell time. Between two consecutive rows it holds a fixed quiet gap with every drive line low. It samples the six sense lines once per row. A sense line reads high when a pressed key connects it to the active drive line. The sense lines have pull-downs, so an open key reads low.

When the last row has been sampled, the scanner copies all thirty results at once into an output snapshot word and raises a done flag. The snapshot stays unchanged until the next scan completes, so the host can shift it out at leisure. The done flag stays high until the serial interface pulses the acknowledge input, which it does at the load edge that ends the readout. All drive lines are low while no scan is in progress.

The dwell and gap lengths are counted in system clocks. With an 8 MHz clock, the defaults of 440 and 2800 clocks give a row drive of 55 µs and a full scan of 1.675 ms.

Top module: `keymat_scanner`

## Requirements
- R1: After reset, and whenever no scan is running, all src_out lines are low; at no time is more than one src_out line high.
- R2: A scan_req seen while idle starts a scan. The driving of row 0 (src_out bit 0) begins in the clock cycle after the request. Rows are driven in ascending order, each for exactly DWELL_CLKS cycles, with GAP_CLKS cycles of all-low src_out between consecutive rows.
- R3: ret_in is sampled in the last cycle of each row's dwell. The value of ret_in[c] during row r lands in key_word bit r*COLS+c, where 1 means pressed and 0 means released. So with the defaults, row 0 gives bits 0..5 and row 4 gives bits 24..29.
- R4: A scan_req that arrives while a scan is running, including in its final cycle, is ignored. It neither restarts nor extends the scan, and it queues no second scan.
- R5: done is low after reset. It is high from the clock edge that ends the last row's dwell, and it is cleared by an edge where ack is high. If completion and ack coincide, done stays high.
- R6: key_word is zero after reset. It changes only at the edge that completes a scan, when all bits update together. It holds its value between scans, even if the keys change.
- R7: A complete scan lasts ROWS*DWELL_CLKS + (ROWS-1)*GAP_CLKS cycles from the accepting edge to the edge that raises done. During that time src_out is non-zero for exactly ROWS*DWELL_CLKS cycles.
- R8: ret_in activity outside the sample cycles, including during gaps and while idle, has no effect on key_word.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| scan_req | input | 1 | One-cycle pulse from the command interface that starts a scan |
| ack | input | 1 | Readout-finished pulse; clears done |
| ret_in | input | COLS | Sense lines from the matrix, high when a pressed key meets the driven row |
| src_out | output | ROWS | Drive lines, one-hot while a row is driven, zero otherwise |
| done | output | 1 | Scan-complete flag |
| key_word | output | ROWS*COLS | Snapshot of key states, bit r*COLS+c |

## Verification
The hardest corners to reach are coincidences at the very last cycle of a scan. In one, an acknowledge lands in the same cycle that completion sets done. In the other, a second request arrives in the last cycle of the scan, while the sequencer is about to return to idle. The bench reaches both by counting cycles from the accepting edge, using the closed-form scan length, and placing the pulse in cycle ROWS*(DWELL+GAP)-GAP-1. A behavioural model computes the expected drive line and sample point from that cycle index and checks the outputs on every clock. Sense-line noise injected only while no row is driven shows that the gaps and idle time are not sampled.

// File: rtl/keymat_pkg.sv
package keymat_pkg;

   typedef enum logic [1:0] {
      SEQ_IDLE  = 2'd0,
      SEQ_DRIVE = 2'd1,
      SEQ_GAP   = 2'd2
   } seq_state_e;

   function automatic int unsigned max2(input int unsigned a, input int unsigned b);
      return (a > b) ? a : b;
   endfunction

endpackage

// File: rtl/keymat_seq.sv
module keymat_seq
   import keymat_pkg::*;
#(
   parameter int unsigned ROWS       = 5,
   parameter int unsigned DWELL_CLKS = 440,
   parameter int unsigned GAP_CLKS   = 2800,
   localparam int unsigned ROW_W     = (ROWS > 1) ? $clog2(ROWS) : 1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             start,
   output logic [ROWS-1:0]  src_out,
   output logic [ROW_W-1:0] row_idx,
   output logic             sample_stb,
   output logic             last_stb,
   output logic             busy
);

   localparam int unsigned CNT_MAX = max2(max2(DWELL_CLKS, GAP_CLKS), 2);
   localparam int unsigned CNT_W   = $clog2(CNT_MAX);
   localparam logic [ROW_W-1:0] LAST_ROW = ROW_W'(ROWS - 1);

   seq_state_e       state;
   seq_state_e       after_dwell;
   logic [CNT_W-1:0] cnt;
   logic             dwell_end;
   logic             gap_end;

   assign dwell_end = (cnt == CNT_W'(DWELL_CLKS - 1));

   generate
      if (GAP_CLKS > 0) begin : g_gap
         assign after_dwell = SEQ_GAP;
         assign gap_end     = (cnt == CNT_W'(GAP_CLKS - 1));
      end else begin : g_nogap
         assign after_dwell = SEQ_DRIVE;
         assign gap_end     = 1'b1;
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state   <= SEQ_IDLE;
         row_idx <= '0;
         cnt     <= '0;
      end else begin
         case (state)
            SEQ_IDLE: begin
               if (start) begin
                  state   <= SEQ_DRIVE;
                  row_idx <= '0;
                  cnt     <= '0;
               end
            end
            SEQ_DRIVE: begin
               if (dwell_end) begin
                  cnt <= '0;
                  if (row_idx == LAST_ROW) begin
                     state <= SEQ_IDLE;
                  end else begin
                     state <= after_dwell;
                     if (after_dwell == SEQ_DRIVE) row_idx <= row_idx + 1'b1;
                  end
               end else begin
                  cnt <= cnt + 1'b1;
               end
            end
            SEQ_GAP: begin
               if (gap_end) begin
                  cnt     <= '0;
                  row_idx <= row_idx + 1'b1;
                  state   <= SEQ_DRIVE;
               end else begin
                  cnt <= cnt + 1'b1;
               end
            end
            default: state <= SEQ_IDLE;
         endcase
      end
   end

   assign busy       = (state != SEQ_IDLE);
   assign sample_stb = (state == SEQ_DRIVE) && dwell_end;
   assign last_stb   = sample_stb && (row_idx == LAST_ROW);

   generate
      for (genvar r = 0; r < ROWS; r++) begin : g_src
         assign src_out[r] = (state == SEQ_DRIVE) && (row_idx == ROW_W'(r));
      end
   endgenerate

   AST_ONE_SOURCE: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(src_out)); // R1

   AST_START_ROW0: assert property (@(posedge clk) disable iff (!rst_n)
      (!busy && start) |=> (src_out == ROWS'(1))); // R2

   AST_ROW_HELD: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && !sample_stb && !gap_end) |=> $stable(row_idx)); // R2

   AST_BUSY_REQ_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && start && !last_stb) |=> busy); // R4

endmodule

// File: rtl/keymat_capture.sv
module keymat_capture #(
   parameter int unsigned ROWS = 5,
   parameter int unsigned COLS = 6,
   localparam int unsigned KEYS  = ROWS * COLS,
   localparam int unsigned ROW_W = (ROWS > 1) ? $clog2(ROWS) : 1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [COLS-1:0]  ret_in,
   input  logic [ROW_W-1:0] row_idx,
   input  logic             sample_stb,
   input  logic             last_stb,
   output logic [KEYS-1:0]  key_word
);

   logic [COLS-1:0] shadow [ROWS];
   logic [KEYS-1:0] fresh;

   generate
      for (genvar r = 0; r < ROWS; r++) begin : g_row
         logic hit;
         assign hit = sample_stb && (row_idx == ROW_W'(r));

         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)   shadow[r] <= '0;
            else if (hit) shadow[r] <= ret_in;
         end

         assign fresh[r*COLS +: COLS] = hit ? ret_in : shadow[r];
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)        key_word <= '0;
      else if (last_stb) key_word <= fresh;
   end

   AST_WORD_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
      !$past(last_stb) |-> $stable(key_word)); // R6

endmodule

// File: rtl/keymat_scanner.sv
module keymat_scanner #(
   parameter int unsigned ROWS       = 5,
   parameter int unsigned COLS       = 6,
   parameter int unsigned DWELL_CLKS = 440,
   parameter int unsigned GAP_CLKS   = 2800,
   localparam int unsigned KEYS      = ROWS * COLS
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            scan_req,
   input  logic            ack,
   input  logic [COLS-1:0] ret_in,
   output logic [ROWS-1:0] src_out,
   output logic            done,
   output logic [KEYS-1:0] key_word
);

   localparam int unsigned ROW_W = (ROWS > 1) ? $clog2(ROWS) : 1;

   generate
      if (ROWS < 1) begin : g_bad_rows
         $error("keymat_scanner: ROWS must be at least 1");
      end
      if (COLS < 1) begin : g_bad_cols
         $error("keymat_scanner: COLS must be at least 1");
      end
      if (DWELL_CLKS < 2) begin : g_bad_dwell
         $error("keymat_scanner: DWELL_CLKS must be at least 2");
      end
   endgenerate

   logic [ROW_W-1:0] row_idx;
   logic             sample_stb;
   logic             last_stb;
   logic             busy;

   keymat_seq #(
      .ROWS       (ROWS),
      .DWELL_CLKS (DWELL_CLKS),
      .GAP_CLKS   (GAP_CLKS)
   ) u_seq (
      .clk        (clk),
      .rst_n      (rst_n),
      .start      (scan_req),
      .src_out    (src_out),
      .row_idx    (row_idx),
      .sample_stb (sample_stb),
      .last_stb   (last_stb),
      .busy       (busy)
   );

   keymat_capture #(
      .ROWS (ROWS),
      .COLS (COLS)
   ) u_cap (
      .clk        (clk),
      .rst_n      (rst_n),
      .ret_in     (ret_in),
      .row_idx    (row_idx),
      .sample_stb (sample_stb),
      .last_stb   (last_stb),
      .key_word   (key_word)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)        done <= 1'b0;
      else if (last_stb) done <= 1'b1;
      else if (ack)      done <= 1'b0;
   end

   AST_DONE_SET: assert property (@(posedge clk) disable iff (!rst_n)
      last_stb |=> done); // R5

   AST_DONE_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
      (ack && !last_stb) |=> !done); // R5

   AST_QUIET_AT_DONE: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(done) |-> (src_out == '0)); // R1

endmodule

// File: tb/keymat_scanner_tb.sv
module keymat_scanner_tb;

   localparam int ROWS  = 5;
   localparam int COLS  = 6;
   localparam int KEYS  = ROWS * COLS;
   localparam int DW    = 6;
   localparam int GP    = 3;
   localparam int PER   = DW + GP;
   localparam int TOTAL = ROWS * PER - GP;

   logic            clk = 1'b0;
   logic            rst_n = 1'b0;
   logic            scan_req = 1'b0;
   logic            ack = 1'b0;
   logic [COLS-1:0] ret_in;
   logic [ROWS-1:0] src_out;
   logic            done;
   logic [KEYS-1:0] key_word;

   always #2 clk = ~clk;

   keymat_scanner #(
      .ROWS (ROWS), .COLS (COLS), .DWELL_CLKS (DW), .GAP_CLKS (GP)
   ) u_dut (
      .clk (clk), .rst_n (rst_n), .scan_req (scan_req), .ack (ack),
      .ret_in (ret_in), .src_out (src_out), .done (done), .key_word (key_word)
   );

   int checks = 0;
   int errors = 0;

   task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   // Matrix emulation: pressed keys close a path from the driven row.
   logic [KEYS-1:0] pressed = '0;
   logic [COLS-1:0] noise = 6'b101101;
   logic            noise_en = 1'b0;

   always_comb begin
      ret_in = '0;
      for (int r = 0; r < ROWS; r++)
         for (int c = 0; c < COLS; c++)
            if (src_out[r] && pressed[r*COLS+c]) ret_in[c] = 1'b1;
      if (noise_en && src_out == '0) ret_in = noise;
   end

   always @(negedge clk) noise <= {noise[4:0], noise[5] ^ noise[4]};

   // Behavioural reference, indexed by cycle position within the scan.
   bit              m_act = 0;
   int              m_t = 0;
   bit              m_done = 0;
   bit              m_fin;
   logic [KEYS-1:0] m_word = '0;
   logic [KEYS-1:0] m_shadow = '0;
   bit              started = 0;

   always @(posedge clk) begin
      started <= 1;
      m_fin = 0;
      if (!rst_n) begin
         m_act = 0; m_t = 0; m_done = 0; m_word = '0; m_shadow = '0;
      end else begin
         if (m_act) begin
            if (m_t % PER == DW - 1)
               for (int c = 0; c < COLS; c++) m_shadow[(m_t / PER) * COLS + c] = ret_in[c];
            if (m_t == TOTAL - 1) begin
               m_act = 0; m_word = m_shadow; m_fin = 1;
            end else begin
               m_t++;
            end
         end else if (scan_req) begin
            m_act = 1; m_t = 0;
         end
         if (m_fin) m_done = 1;
         else if (ack) m_done = 0;
      end
   end

   function automatic logic [ROWS-1:0] exp_src();
      if (m_act && (m_t % PER) < DW) return ROWS'(1) << (m_t / PER);
      return '0;
   endfunction

   always @(negedge clk) begin
      if (started) begin
         chk("R2 src_out per-cycle", 64'(src_out), 64'(exp_src()));
         chk("R5 done per-cycle", 64'(done), 64'(m_done));
         chk("R6 key_word per-cycle", 64'(key_word), 64'(m_word));
      end
   end

   int len;
   int act;

   task automatic do_scan(input bit ack_last, input bit extra_req);
      @(negedge clk); scan_req = 1'b1;
      @(negedge clk); scan_req = 1'b0;
      len = 0; act = 0;
      for (int k = 0; k < 1000; k++) begin
         if (src_out != '0) act++;
         scan_req = extra_req && (k == 10 || k == TOTAL - 1);
         ack = ack_last && (k == TOTAL - 1);
         if (done) break;
         len++;
         @(negedge clk);
      end
      scan_req = 1'b0;
      ack = 1'b0;
   endtask

   task automatic ack_pulse();
      @(negedge clk); ack = 1'b1;
      @(negedge clk); ack = 1'b0;
      chk("R5 done cleared by ack", 64'(done), 64'(0));
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      errors++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin
      repeat (4) @(negedge clk);
      chk("R1 src_out idle in reset", 64'(src_out), 64'(0));
      chk("R5 done low after reset", 64'(done), 64'(0));
      chk("R6 key_word zero after reset", 64'(key_word), 64'(0));
      rst_n = 1'b1;
      repeat (3) @(negedge clk);
      chk("R1 src_out idle before scan", 64'(src_out), 64'(0));

      // corner keys: first and last index
      pressed = '0; pressed[0] = 1'b1; pressed[29] = 1'b1;
      do_scan(0, 0);
      chk("R7 scan length", 64'(len), 64'(TOTAL));
      chk("R2 driven cycles", 64'(act), 64'(ROWS * DW));
      chk("R3 keys 0 and 29", 64'(key_word), 64'((64'd1 << 29) | 64'd1));
      chk("R5 done set at completion", 64'(done), 64'(1));
      chk("R1 src_out low after scan", 64'(src_out), 64'(0));
      ack_pulse();

      // noise on sense lines while no row is driven
      pressed = '0; pressed[7] = 1'b1; pressed[12] = 1'b1; pressed[23] = 1'b1;
      noise_en = 1'b1;
      do_scan(0, 0);
      chk("R8 gap noise ignored", 64'(key_word), 64'(pressed));
      chk("R3 keys 7,12,23", 64'(key_word), 64'((64'd1 << 7) | (64'd1 << 12) | (64'd1 << 23)));
      repeat (5) @(negedge clk);
      chk("R8 idle noise ignored", 64'(key_word), 64'(pressed));
      noise_en = 1'b0;
      ack_pulse();

      // requests while busy, including in the final cycle
      pressed = 30'h2AAA_AAAA;
      do_scan(0, 1);
      chk("R4 scan length with extra req", 64'(len), 64'(TOTAL));
      chk("R3 alternate pattern", 64'(key_word), 64'(30'h2AAA_AAAA));
      repeat (6) @(negedge clk);
      chk("R4 no second scan", 64'(src_out), 64'(0));
      ack_pulse();

      // ack coincides with completion
      pressed = '1;
      do_scan(1, 0);
      chk("R5 set wins over ack", 64'(done), 64'(1));
      chk("R3 all keys", 64'(key_word), 64'({KEYS{1'b1}}));

      // key changes without a scan
      pressed = '0;
      repeat (20) @(negedge clk);
      chk("R6 word held between scans", 64'(key_word), 64'({KEYS{1'b1}}));
      ack_pulse();

      do_scan(0, 0);
      chk("R3 all released", 64'(key_word), 64'(0));
      ack_pulse();
      repeat (3) @(negedge clk);

      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

endmodule